// File: doc/BRIEF.md
# Fault Escalation and Dispatch Controller

This block decides how a reported page fault is delivered to its handler. On a fault request it tries the handler table entry for the page-fault vector (14). The attempt fails when the entry is not present, when the handler's code segment is invalid, or when the frame would push the stack pointer below a configured limit. A failed attempt is retried once as a double fault (vector 8). If that attempt also fails, the block asserts a one-cycle system reset.

When an attempt succeeds, the block works out the stack the frame lands on and pushes the frame one word per cycle on a write port. If the handler runs at a more privileged ring than the interrupted code, the frame goes on a fresh stack and starts with the old stack segment and stack pointer. If the ring does not change, the frame goes on the interrupted stack and those two words are left out. A one-cycle done pulse then carries the chosen vector.

The escalation level stays raised while the handler runs, and a return input brings it back to normal. Memory writes, descriptor contents and handler execution are left to the surroundings.

Top module: `fault_escalator`

## Requirements
- R1: While reset is held, and at the first sample after it, pushValid, dispatchDone and sysReset are 0 and escLevel is 0. escLevel encodes 0 for normal, 1 for a page fault in progress and 2 for a double fault in progress.
- R2: A faultReq seen while idle latches the frame inputs and sets escLevel to 1 one cycle later. If the page-fault attempt succeeds, the dispatch is reported with vector 14.
- R3: An attempt fails when gateOk[v] is 0, when csOk[v] is 0, or when the stack check of R8 fails. Bit 0 of gateOk and csOk belongs to the page fault and bit 1 to the double fault. A failed page-fault attempt sets escLevel to 2 and retries as vector 8, with the pushed error word forced to 0.
- R4: A failed double-fault attempt raises sysReset for exactly one cycle, returns escLevel to 0 and pushes nothing.
- R5: When handlerRing is numerically smaller than the latched curRing, the base stack pointer is newSp and six words are pushed in this order: oldSs, oldEsp, eflagsIn, oldCs, oldEip, error word.
- R6: When handlerRing is not smaller than curRing, the base is oldEsp and four words are pushed in this order: eflagsIn, oldCs, oldEip, error word.
- R7: Pushes come in consecutive cycles. The first push address is base−4, and each later address is 4 below the one before it.
- R8: The stack check fails when base − 4·(number of words) is below stackLimit (unsigned compare) or would wrap below zero.
- R9: dispatchDone pulses for one cycle, in the cycle right after the last push, with dispatchVector set to 14 at level 1 or 8 at level 2.
- R10: Each delivery attempt takes one cycle. Pushes start in the cycle after the successful attempt, and a reset pulse comes in the cycle after the second failed attempt.
- R11: After dispatch, escLevel holds until retIn, and drops to 0 one cycle after it. A faultReq that arrives while not idle is ignored: it causes no pushes and does not change escLevel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| faultReq | input | 1 | Page fault reported |
| errCode | input | 32 | Page-fault error word |
| oldSs | input | 32 | Interrupted stack segment |
| oldEsp | input | 32 | Interrupted stack pointer |
| eflagsIn | input | 32 | Interrupted flags |
| oldCs | input | 32 | Interrupted code segment |
| oldEip | input | 32 | Interrupted instruction pointer |
| curRing | input | 2 | Ring of the interrupted code |
| handlerRing | input | 2 | Ring of the handler |
| newSp | input | 32 | Stack pointer loaded on a ring change |
| stackLimit | input | 32 | Lowest legal stack address |
| gateOk | input | 2 | Table entry present, per vector |
| csOk | input | 2 | Handler code segment valid, per vector |
| retIn | input | 1 | Handler has returned |
| pushValid | output | 1 | Frame word write strobe |
| pushAddr | output | 32 | Frame word address |
| pushData | output | 32 | Frame word value |
| dispatchDone | output | 1 | Dispatch complete pulse |
| dispatchVector | output | 8 | Vector delivered |
| sysReset | output | 1 | Triple-fault reset pulse |
| escLevel | output | 2 | Escalation level |

## Verification
If a request is sampled at edge 0, the first attempt shows at the following sample, the retry (when there is one) one cycle later, and the reset pulse one cycle after the second failure. A successful dispatch puts its N pushes in the cycles just after the winning attempt and the done pulse right after those. The bench samples at the falling edge and works out in advance, for every cycle of an episode, whether a push, a done pulse or a reset is due, so a late or early strobe counts as a failure. Escalation-level and ignored-request checks come one cycle after their stimulus.

// File: rtl/fault_escalator_pkg.sv
package fault_escalator_pkg;
  typedef enum logic [1:0] {LVL_NORMAL = 2'd0, LVL_PF = 2'd1, LVL_DF = 2'd2} level_t;
  typedef enum logic [2:0] {ST_IDLE, ST_CHECK, ST_PUSH, ST_DONE, ST_ACTIVE} state_t;
  typedef struct packed {
    logic capture;
    logic loadSp;
    logic push;
    logic clearErr;
    logic isDf;
  } ctrl_t;
endpackage

// File: rtl/fault_escalator_dp.sv
module fault_escalator_dp
  import fault_escalator_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RING_W = 2,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] errCode,
  input  logic [DATA_W-1:0] oldSs,
  input  logic [DATA_W-1:0] oldEsp,
  input  logic [DATA_W-1:0] eflagsIn,
  input  logic [DATA_W-1:0] oldCs,
  input  logic [DATA_W-1:0] oldEip,
  input  logic [RING_W-1:0] curRing,
  input  logic [RING_W-1:0] handlerRing,
  input  logic [DATA_W-1:0] newSp,
  input  logic [DATA_W-1:0] stackLimit,
  input  logic [1:0]        gateOk,
  input  logic [1:0]        csOk,
  output logic              deliverOk,
  output logic              lastPush,
  output logic [DATA_W-1:0] pushAddr,
  output logic [DATA_W-1:0] pushData
);
  localparam int FRAME_WORDS = 6;
  localparam int SHORT_WORDS = 4;
  localparam int FIRST_SHORT = FRAME_WORDS - SHORT_WORDS;
  localparam int IDX_W = $clog2(FRAME_WORDS);
  localparam logic [DATA_W:0] FULL_BYTES  = (DATA_W+1)'(FRAME_WORDS * WORD_BYTES);
  localparam logic [DATA_W:0] SHORT_BYTES = (DATA_W+1)'(SHORT_WORDS * WORD_BYTES);

  logic [DATA_W-1:0] ssR, espR, flagsR, csR, eipR, errR, spR;
  logic [RING_W-1:0] ringR;
  logic [IDX_W-1:0]  idxR;
  logic              privChange, stackOk;
  logic [DATA_W-1:0] baseSp;
  logic [DATA_W:0]   endSp;
  logic [DATA_W-1:0] frameW [FRAME_WORDS];

  assign privChange = handlerRing < ringR;
  assign baseSp     = privChange ? newSp : espR;
  assign endSp      = {1'b0, baseSp} - (privChange ? FULL_BYTES : SHORT_BYTES);
  assign stackOk    = !endSp[DATA_W] && (endSp[DATA_W-1:0] >= stackLimit);
  assign deliverOk  = gateOk[ctrl.isDf] && csOk[ctrl.isDf] && stackOk;

  assign frameW[0] = ssR;
  assign frameW[1] = espR;
  assign frameW[2] = flagsR;
  assign frameW[3] = csR;
  assign frameW[4] = eipR;
  assign frameW[5] = errR;

  assign pushAddr = spR - DATA_W'(WORD_BYTES);
  assign pushData = frameW[idxR];
  assign lastPush = idxR == IDX_W'(FRAME_WORDS - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ssR <= '0; espR <= '0; flagsR <= '0; csR <= '0; eipR <= '0; errR <= '0;
      ringR <= '0; spR <= '0; idxR <= '0;
    end else begin
      if (ctrl.capture) begin
        ssR <= oldSs; espR <= oldEsp; flagsR <= eflagsIn;
        csR <= oldCs; eipR <= oldEip; errR <= errCode; ringR <= curRing;
      end
      if (ctrl.clearErr) errR <= '0;
      if (ctrl.loadSp) begin
        spR  <= baseSp;
        idxR <= privChange ? '0 : IDX_W'(FIRST_SHORT);
      end else if (ctrl.push) begin
        spR  <= pushAddr;
        idxR <= idxR + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fault_escalator_ctrl.sv
module fault_escalator_ctrl
  import fault_escalator_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  faultReq,
  input  logic  retIn,
  input  logic  deliverOk,
  input  logic  lastPush,
  output ctrl_t ctrl,
  output logic  dispatchDone,
  output logic  sysReset,
  output level_t level
);
  state_t state;

  always_comb begin
    ctrl          = '0;
    ctrl.isDf     = level == LVL_DF;
    ctrl.capture  = state == ST_IDLE && faultReq;
    ctrl.loadSp   = state == ST_CHECK && deliverOk;
    ctrl.clearErr = state == ST_CHECK && !deliverOk && level == LVL_PF;
    ctrl.push     = state == ST_PUSH;
    dispatchDone  = state == ST_DONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      level    <= LVL_NORMAL;
      sysReset <= 1'b0;
    end else begin
      sysReset <= 1'b0;
      unique case (state)
        ST_IDLE: if (faultReq) begin
          level <= LVL_PF;
          state <= ST_CHECK;
        end
        ST_CHECK: begin
          if (deliverOk) state <= ST_PUSH;
          else if (level == LVL_PF) level <= LVL_DF;
          else begin
            sysReset <= 1'b1;
            level    <= LVL_NORMAL;
            state    <= ST_IDLE;
          end
        end
        ST_PUSH: if (lastPush) state <= ST_DONE;
        ST_DONE: state <= ST_ACTIVE;
        ST_ACTIVE: if (retIn) begin
          level <= LVL_NORMAL;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fault_escalator.sv
module fault_escalator
  import fault_escalator_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RING_W = 2,
  parameter int VEC_W = 8,
  parameter int PF_VEC = 14,
  parameter int DF_VEC = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              faultReq,
  input  logic [DATA_W-1:0] errCode,
  input  logic [DATA_W-1:0] oldSs,
  input  logic [DATA_W-1:0] oldEsp,
  input  logic [DATA_W-1:0] eflagsIn,
  input  logic [DATA_W-1:0] oldCs,
  input  logic [DATA_W-1:0] oldEip,
  input  logic [RING_W-1:0] curRing,
  input  logic [RING_W-1:0] handlerRing,
  input  logic [DATA_W-1:0] newSp,
  input  logic [DATA_W-1:0] stackLimit,
  input  logic [1:0]        gateOk,
  input  logic [1:0]        csOk,
  input  logic              retIn,
  output logic              pushValid,
  output logic [DATA_W-1:0] pushAddr,
  output logic [DATA_W-1:0] pushData,
  output logic              dispatchDone,
  output logic [VEC_W-1:0]  dispatchVector,
  output logic              sysReset,
  output logic [1:0]        escLevel
);
  ctrl_t  ctrl;
  level_t level;
  logic   deliverOk, lastPush;

  fault_escalator_ctrl ctrl_i (
    .clk, .rstN, .faultReq, .retIn, .deliverOk, .lastPush,
    .ctrl, .dispatchDone, .sysReset, .level
  );

  fault_escalator_dp #(.DATA_W(DATA_W), .RING_W(RING_W)) dp_i (
    .clk, .rstN, .ctrl, .errCode, .oldSs, .oldEsp, .eflagsIn, .oldCs, .oldEip,
    .curRing, .handlerRing, .newSp, .stackLimit, .gateOk, .csOk,
    .deliverOk, .lastPush, .pushAddr, .pushData
  );

  assign pushValid      = ctrl.push;
  assign dispatchVector = ctrl.isDf ? VEC_W'(DF_VEC) : VEC_W'(PF_VEC);
  assign escLevel       = level;
endmodule

// File: rtl/fault_escalator_chk.sv
module fault_escalator_chk #(
  parameter int DATA_W = 32,
  parameter int VEC_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              pushValid,
  input logic [DATA_W-1:0] pushAddr,
  input logic              dispatchDone,
  input logic [VEC_W-1:0]  dispatchVector,
  input logic              sysReset,
  input logic [1:0]        escLevel
);
  // R4
  reset_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysReset |=> !sysReset);
  // R4
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysReset |-> (escLevel == 2'd0 && !pushValid && !dispatchDone));
  // R7
  push_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && $past(pushValid)) |-> pushAddr == $past(pushAddr) - DATA_W'(4));
  // R9
  done_after_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pushValid) |-> dispatchDone);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    dispatchDone |=> !dispatchDone);
  // R9
  done_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    dispatchDone |-> ((escLevel == 2'd1 && dispatchVector == VEC_W'(14)) ||
                      (escLevel == 2'd2 && dispatchVector == VEC_W'(8))));
  // R1
  level_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    escLevel != 2'd3);
endmodule

bind fault_escalator fault_escalator_chk #(.DATA_W(DATA_W), .VEC_W(VEC_W)) chk_i (
  .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushAddr(pushAddr),
  .dispatchDone(dispatchDone), .dispatchVector(dispatchVector),
  .sysReset(sysReset), .escLevel(escLevel)
);

// File: tb/fault_escalator_tb_top.sv
module fault_escalator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic        clk = 0, rstN = 0, faultReq = 0, retIn = 0;
  logic [31:0] errCode = 0, oldSs = 0, oldEsp = 0, eflagsIn = 0, oldCs = 0, oldEip = 0;
  logic [31:0] newSp = 0, stackLimit = 0;
  logic [1:0]  curRing = 0, handlerRing = 0, gateOk = 0, csOk = 0;
  logic        pushValid, dispatchDone, sysReset;
  logic [31:0] pushAddr, pushData;
  logic [7:0]  dispatchVector;
  logic [1:0]  escLevel;

  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_escalator dut_i (
    .clk, .rstN, .faultReq, .errCode, .oldSs, .oldEsp, .eflagsIn, .oldCs, .oldEip,
    .curRing, .handlerRing, .newSp, .stackLimit, .gateOk, .csOk, .retIn,
    .pushValid, .pushAddr, .pushData, .dispatchDone, .dispatchVector, .sysReset, .escLevel
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit privOf();
    return handlerRing < curRing;
  endfunction

  function automatic logic [31:0] baseOf();
    return privOf() ? newSp : oldEsp;
  endfunction

  function automatic bit stackGood();
    logic [32:0] e;
    e = {1'b0, baseOf()} - (privOf() ? 33'd24 : 33'd16);
    return !e[32] && e[31:0] >= stackLimit;
  endfunction

  function automatic logic [31:0] wordOf(int k, bit df);
    logic [31:0] w [6];
    w = '{oldSs, oldEsp, eflagsIn, oldCs, oldEip, df ? 32'd0 : errCode};
    return w[privOf() ? k : k + 2];
  endfunction

  task automatic runEpisode();
    bit pfOk, dfOk, df, rst;
    int chkCycles, np, endC;
    pfOk = gateOk[0] && csOk[0] && stackGood();
    dfOk = gateOk[1] && csOk[1] && stackGood();
    df   = !pfOk;
    rst  = !pfOk && !dfOk;
    chkCycles = df ? 2 : 1;
    np   = privOf() ? 6 : 4;
    endC = rst ? 3 : chkCycles + np + 1;
    @(negedge clk); faultReq = 1;
    @(negedge clk); faultReq = 0;
    chk("R2 level after request", escLevel, 1);
    for (int c = 1; c <= endC; c++) begin
      if (c > 1) @(negedge clk);
      if (rst) begin
        chk("R4 sysReset timing", sysReset, c == 3);
        chk("R4 no push", pushValid, 0);
        if (c == 2) chk("R3 level after failed attempt", escLevel, 2);
        if (c == 3) chk("R4 level cleared", escLevel, 0);
      end else begin
        bit pv;
        pv = c > chkCycles && c <= chkCycles + np;
        chk("R10 push timing", pushValid, pv);
        chk("R9 done timing", dispatchDone, c == endC);
        chk("R4 no reset", sysReset, 0);
        if (pv) begin
          int k;
          k = c - chkCycles - 1;
          chk(privOf() ? "R5 push data" : "R6 push data", pushData, wordOf(k, df));
          chk("R7 push address", pushAddr, baseOf() - 32'(4 * (k + 1)));
        end
        if (c == endC) begin
          chk(df ? "R3 vector 8" : "R2 vector 14", dispatchVector, df ? 8 : 14);
          chk("R8 stack outcome", escLevel, df ? 2 : 1);
        end
      end
    end
    if (!rst) begin
      faultReq = 1;
      @(negedge clk); faultReq = 0;
      chk("R11 ignored request no push", pushValid, 0);
      chk("R11 ignored request level", escLevel, df ? 2 : 1);
      retIn = 1;
      @(negedge clk); retIn = 0;
      chk("R11 level after return", escLevel, 0);
    end else begin
      @(negedge clk);
      chk("R4 reset pulse ends", sysReset, 0);
    end
  endtask

  task automatic randFrame();
    errCode = $urandom; oldSs = $urandom; eflagsIn = $urandom;
    oldCs = $urandom; oldEip = $urandom;
    oldEsp = 32'h1000 + ($urandom % 32'h10000);
    newSp  = 32'h20000 + ($urandom % 32'h10000);
    curRing = 2'($urandom); handlerRing = 2'($urandom);
    gateOk = ($urandom % 4 == 0) ? 2'($urandom) : 2'b11;
    csOk   = ($urandom % 4 == 0) ? 2'($urandom) : 2'b11;
    stackLimit = baseOf() - 32'($urandom % 40);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset pushValid", pushValid, 0);
    chk("R1 reset level", escLevel, 0);
    rstN = 1;
    @(negedge clk);
    chk("R1 after reset done", dispatchDone, 0);
    chk("R1 after reset sysReset", sysReset, 0);
    // R5 directed: ring change, all good
    randFrame(); curRing = 3; handlerRing = 0; gateOk = 3; csOk = 3; stackLimit = 0;
    runEpisode();
    // R6 directed: same ring
    randFrame(); curRing = 0; handlerRing = 0; gateOk = 3; csOk = 3; stackLimit = 0;
    runEpisode();
    // R3 directed: missing page-fault entry
    randFrame(); gateOk = 2'b10; csOk = 3; stackLimit = 0;
    runEpisode();
    // R4 directed: both code segments bad
    randFrame(); gateOk = 3; csOk = 2'b00;
    runEpisode();
    // R8 directed: wrap below zero
    randFrame(); curRing = 0; handlerRing = 0; oldEsp = 8; stackLimit = 0; gateOk = 3; csOk = 3;
    runEpisode();
    // R8 directed: exactly at the limit passes
    randFrame(); curRing = 1; handlerRing = 1; gateOk = 3; csOk = 3; stackLimit = oldEsp - 16;
    runEpisode();
    // R8 directed: one word short of the limit fails to reset
    randFrame(); curRing = 2; handlerRing = 0; gateOk = 3; csOk = 3; stackLimit = newSp - 20;
    runEpisode();
    for (int i = 0; i < 400; i++) begin
      randFrame();
      runEpisode();
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule